// File: doc/BRIEF.md
# CRC-Checked Block Flash Reader

This block sits between a word consumer and a 16-bit parallel flash controller. The consumer asks for one data word at a time by logical word address. The flash is laid out in blocks of 512 data words. Each block is followed directly by one extra word that holds the CRC of those 512 words. When a request falls outside the block currently held, the reader requests ownership of the flash. It streams the whole block, CRC word included, into an on-chip buffer and runs a CRC over the data words as they arrive. It answers the consumer only once the computed CRC equals the stored one.

A mismatch is treated as a transient read fault. The buffer is thrown away and the block is fetched again from its first word. After four consecutive bad attempts on one block the reader gives up. It completes the request with a zero word and sets a sticky error flag. Requests that land inside the verified block are answered from the buffer without touching flash. The flash port uses a held ownership request with a grant, and one read strobe per word with a single read outstanding. The returned word is flagged by a valid pulse whose latency is free.

Top module: `blk_flash_reader`

## Requirements
- R1: Data word `a` (block `b = a / 512`, offset `k = a % 512`) lives at flash word address `b*513 + k`, and the 16-bit CRC of block `b` lives at flash word address `b*513 + 512`.
- R2: The CRC is computed over the 512 data words in offset order. Each word enters most significant bit first, with generator 0x1021, start value 0xFFFF and no final inversion. The block is accepted only if the result equals the stored CRC word.
- R3: On a request to a block not held and verified, every word of that block is read (all 513 words in ascending address order) before the request is answered.
- R4: On a CRC mismatch the buffered contents are discarded. The complete block is read again starting at its first word, and the word returned afterwards is the correct flash content.
- R5: A request is answered by `req_ready` high for exactly one cycle with `req_data` equal to the data word at `req_addr`, and only after the holding block has passed its CRC check.
- R6: A request inside the block already held and verified is served without any flash read, with `req_ready` high in the first cycle after the clock edge that samples the request.
- R7: After 4 consecutive failed checks on the same block, no further attempt is made. The request completes with `req_data` = 0, and `err_sticky` goes high and stays high until reset.
- R8: `fl_own_req` is high for the whole of each fill attempt and low in the cycle the CRC is judged. `fl_rd` is only asserted while `fl_own_req` and `fl_gnt` are both high, and never twice with a word still outstanding.
- R9: Reset clears `req_ready`, `fl_own_req`, `fl_rd` and `err_sticky`, and invalidates the buffer, so the first request afterwards always reads flash.
- R10: A block abandoned under R7 is not held as verified, and a later request to it reads flash again and returns correct data if the reads are clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Consumer request, held until `req_ready` |
| req_addr | input | LADDR_W (12) | Logical data word address |
| req_ready | output | 1 | One-cycle completion; `req_data` valid |
| req_data | output | 16 | Returned word (0 on give-up) |
| err_sticky | output | 1 | Set when a block fails 4 checks in a row |
| fl_own_req | output | 1 | Flash ownership request, held across a fill attempt |
| fl_gnt | input | 1 | Flash ownership granted |
| fl_rd | output | 1 | One-cycle word read strobe |
| fl_addr | output | FADDR_W (16) | Flash word address for `fl_rd` |
| fl_valid | input | 1 | Returned flash word is valid |
| fl_data | input | 16 | Returned flash word |

## Verification
A buffer hit answers in the first cycle after the sampling edge. The bench counts negative edges from the request and demands exactly one for every hit. A miss answers only after 513 flash reads per attempt, one judge cycle and one buffer read cycle. The bench does not predict that latency. It waits for `req_ready` at each falling edge and then compares data, the number of fill attempts, the reads in the last attempt and the error flag against values worked out from the flash pattern and the number of corrupted attempts it injected. The flash model samples every read strobe at the rising edge, so ordering and grant rules are checked on every word.

// File: rtl/flr_pkg.sv
package flr_pkg;
  localparam int FLR_WORD_W = 16;
  localparam logic [15:0] FLR_CRC_INIT = 16'hFFFF;
  localparam logic [15:0] FLR_CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_CHECK,
    S_READ,
    S_FAILRSP
  } flr_state_e;

  // advance the CRC register by one word, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [15:0] word);
    logic [15:0] r;
    logic        fb;
    r = crc_in;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ word[i];
      r  = {r[14:0], 1'b0} ^ (fb ? FLR_CRC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/flr_crc_acc.sv
module flr_crc_acc
  import flr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [15:0] din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= FLR_CRC_INIT;
    else if (clr) crc <= FLR_CRC_INIT;
    else if (en)  crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/flr_buf_ram.sv
module flr_buf_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/flr_fill_ctrl.sv
module flr_fill_ctrl
  import flr_pkg::*;
#(
  parameter int LADDR_W   = 12,
  parameter int BLK_WORDS = 512,
  parameter int FADDR_W   = 16,
  parameter int MAX_TRIES = 4,
  localparam int BLK_W  = $clog2(BLK_WORDS),
  localparam int NBLK_W = LADDR_W - BLK_W,
  localparam int IDX_W  = BLK_W + 1,
  localparam int TRY_W  = $clog2(MAX_TRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  output logic               req_ready,
  output logic               rsp_zero,
  output logic               err_sticky,
  output logic               fl_own_req,
  input  logic               fl_gnt,
  output logic               fl_rd,
  output logic [FADDR_W-1:0] fl_addr,
  input  logic               fl_valid,
  input  logic [15:0]        fl_data,
  output logic               crc_clr,
  output logic               crc_en,
  input  logic [15:0]        crc_val,
  output logic               ram_we,
  output logic [BLK_W-1:0]   ram_waddr,
  output logic               ram_re,
  output logic [BLK_W-1:0]   ram_raddr,
  output logic               ev_fill_done,
  output logic               ev_pass,
  output logic               ev_fail,
  output logic               ev_give_up
);
  localparam logic [FADDR_W-1:0] STRIDE = FADDR_W'(BLK_WORDS + 1);

  flr_state_e        state;
  logic [NBLK_W-1:0] cur_blk;
  logic [BLK_W-1:0]  off_q;
  logic [IDX_W-1:0]  idx;
  logic [TRY_W-1:0]  tries;
  logic [15:0]       stored;
  logic              pend;
  logic              buf_ok;

  logic [NBLK_W-1:0] req_blk;
  logic [BLK_W-1:0]  req_off;
  logic              hit;
  logic              last_word;
  logic              got;
  logic              miss_start;

  assign req_blk    = req_addr[LADDR_W-1:BLK_W];
  assign req_off    = req_addr[BLK_W-1:0];
  assign hit        = buf_ok && (req_blk == cur_blk);
  assign miss_start = (state == S_IDLE) && req_valid && !hit;
  assign last_word  = (idx == IDX_W'(BLK_WORDS));
  assign got        = (state == S_FILL) && pend && fl_valid;

  assign fl_own_req = (state == S_FILL);
  assign fl_rd      = (state == S_FILL) && !pend && fl_gnt;
  assign fl_addr    = FADDR_W'(cur_blk) * STRIDE + FADDR_W'(idx);

  assign ram_we     = got && !last_word;
  assign ram_waddr  = idx[BLK_W-1:0];
  assign crc_en     = ram_we;

  assign ev_fill_done = got && last_word;
  assign ev_pass      = (state == S_CHECK) && (crc_val == stored);
  assign ev_fail      = (state == S_CHECK) && (crc_val != stored);
  assign ev_give_up   = ev_fail && (tries == TRY_W'(MAX_TRIES - 1));

  assign crc_clr    = miss_start || (ev_fail && !ev_give_up);
  assign ram_re     = ((state == S_IDLE) && req_valid && hit) || ev_pass;
  assign ram_raddr  = (state == S_IDLE) ? req_off : off_q;

  assign req_ready  = (state == S_READ) || (state == S_FAILRSP);
  assign rsp_zero   = (state == S_FAILRSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_blk    <= '0;
      off_q      <= '0;
      idx        <= '0;
      tries      <= '0;
      stored     <= '0;
      pend       <= 1'b0;
      buf_ok     <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (hit) begin
              state <= S_READ;
            end else begin
              cur_blk <= req_blk;
              off_q   <= req_off;
              buf_ok  <= 1'b0;
              idx     <= '0;
              tries   <= '0;
              pend    <= 1'b0;
              state   <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (fl_rd) pend <= 1'b1;
          if (got) begin
            pend <= 1'b0;
            idx  <= idx + 1'b1;
            if (last_word) begin
              stored <= fl_data;
              state  <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (ev_pass) begin
            buf_ok <= 1'b1;
            state  <= S_READ;
          end else if (ev_give_up) begin
            err_sticky <= 1'b1;
            state      <= S_FAILRSP;
          end else begin
            tries <= tries + 1'b1;
            idx   <= '0;
            state <= S_FILL;
          end
        end
        S_READ:    state <= S_IDLE;
        S_FAILRSP: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_flash_reader.sv
module blk_flash_reader
  import flr_pkg::*;
#(
  parameter int LADDR_W   = 12,
  parameter int BLK_WORDS = 512,
  parameter int FADDR_W   = 16,
  parameter int MAX_TRIES = 4,
  localparam int BLK_W = $clog2(BLK_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  output logic               req_ready,
  output logic [15:0]        req_data,
  output logic               err_sticky,
  output logic               fl_own_req,
  input  logic               fl_gnt,
  output logic               fl_rd,
  output logic [FADDR_W-1:0] fl_addr,
  input  logic               fl_valid,
  input  logic [15:0]        fl_data
);
  logic             crc_clr, crc_en;
  logic [15:0]      crc_val;
  logic             ram_we, ram_re;
  logic [BLK_W-1:0] ram_waddr, ram_raddr;
  logic [15:0]      ram_q;
  logic             rsp_zero;
  logic             ev_fill_done, ev_pass, ev_fail, ev_give_up;

  flr_fill_ctrl #(
    .LADDR_W(LADDR_W), .BLK_WORDS(BLK_WORDS),
    .FADDR_W(FADDR_W), .MAX_TRIES(MAX_TRIES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_zero(rsp_zero), .err_sticky(err_sticky),
    .fl_own_req(fl_own_req), .fl_gnt(fl_gnt), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_data(fl_data),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_val(crc_val),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ev_fill_done(ev_fill_done), .ev_pass(ev_pass), .ev_fail(ev_fail),
    .ev_give_up(ev_give_up)
  );

  flr_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(fl_data), .crc(crc_val)
  );

  flr_buf_ram #(.DEPTH(BLK_WORDS), .WIDTH(FLR_WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(fl_data),
    .re(ram_re), .raddr(ram_raddr), .q(ram_q)
  );

  assign req_data = rsp_zero ? 16'h0000 : ram_q;
endmodule

// File: rtl/flr_checker.sv
module flr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fl_rd,
  input logic        fl_own_req,
  input logic        fl_gnt,
  input logic        req_ready,
  input logic [15:0] req_data,
  input logic        err_sticky,
  input logic        ev_fill_done,
  input logic        ev_pass,
  input logic        ev_fail,
  input logic        ev_give_up
);
  AST_RD_OWNED_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) fl_rd |-> (fl_own_req && fl_gnt)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) fl_rd |=> !fl_rd); // R8
  AST_OWN_LOW_AT_JUDGE: assert property (@(posedge clk) disable iff (!rst_n) (ev_pass || ev_fail) |-> !fl_own_req); // R8
  AST_NO_ANSWER_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n) fl_own_req |-> !req_ready); // R3
  AST_JUDGE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n) ev_fill_done |=> (ev_pass || ev_fail)); // R2
  AST_REFILL_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n) (ev_fail && !ev_give_up) |=> fl_own_req); // R4
  AST_ANSWER_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n) ev_pass |=> req_ready); // R5
  AST_GIVE_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ev_give_up |=> (req_ready && req_data == 16'h0000 && err_sticky)); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) err_sticky |=> err_sticky); // R7
endmodule

bind blk_flash_reader flr_checker i_flr_checker (
  .clk(clk), .rst_n(rst_n), .fl_rd(fl_rd), .fl_own_req(fl_own_req),
  .fl_gnt(fl_gnt), .req_ready(req_ready), .req_data(req_data),
  .err_sticky(err_sticky), .ev_fill_done(ev_fill_done), .ev_pass(ev_pass),
  .ev_fail(ev_fail), .ev_give_up(ev_give_up)
);

// File: tb/test_blk_flash_reader.sv
module test_blk_flash_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_ready;
  logic [15:0] req_data;
  logic        err_sticky;
  logic        fl_own_req;
  logic        fl_gnt;
  logic        fl_rd;
  logic [15:0] fl_addr;
  logic        fl_valid;
  logic [15:0] fl_data;

  always #10 clk = ~clk;

  blk_flash_reader i_blk_flash_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .req_data(req_data), .err_sticky(err_sticky),
    .fl_own_req(fl_own_req), .fl_gnt(fl_gnt), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_data(fl_data)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int mon_checks = 0;
  int mon_fails  = 0;
  int fills_total = 0;
  int reads_in_fill = 0;
  int base_fills = 0;
  int bad_target = 0;

  // flash pattern for a data word at flash address a
  function automatic logic [15:0] fdata(input int a);
    logic [31:0] p;
    p = a * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  // bit-serial CRC over one block, feedback taps placed by hand
  function automatic logic [15:0] bench_crc(input int blk);
    logic [15:0] r;
    logic [15:0] w;
    logic        fb;
    r = 16'hFFFF;
    for (int k = 0; k < 512; k++) begin
      w = fdata(blk * 513 + k);
      for (int b = 15; b >= 0; b--) begin
        fb = r[15] ^ w[b];
        r = {r[14:0], fb};
        r[5]  = r[5] ^ fb;
        r[12] = r[12] ^ fb;
      end
    end
    return r;
  endfunction

  // flash model: grant follows ownership by one cycle, data two edges after the strobe
  initial begin
    logic        d1;
    logic [15:0] d1_data;
    logic        corrupt_now;
    int          last_addr;
    int          off;
    int          blk;
    d1 = 1'b0; d1_data = '0; corrupt_now = 1'b0; last_addr = 0;
    fl_gnt = 1'b0; fl_valid = 1'b0; fl_data = '0;
    forever begin
      @(posedge clk);
      fl_valid <= d1;
      fl_data  <= d1_data;
      fl_gnt   <= fl_own_req;
      d1 = 1'b0;
      if (rst_n && fl_rd) begin
        off = int'(fl_addr) % 513;
        blk = int'(fl_addr) / 513;
        mon_checks++;
        if (!fl_gnt || !fl_own_req) begin
          mon_fails++;
          $display("FAIL R8: read strobe without ownership/grant own=%0d gnt=%0d (expected 1/1)", fl_own_req, fl_gnt);
        end
        if (off == 0) begin
          corrupt_now = (fills_total - base_fills) < bad_target;
          fills_total++;
          reads_in_fill = 1;
        end else begin
          mon_checks++;
          if (int'(fl_addr) != last_addr + 1) begin
            mon_fails++;
            $display("FAIL R3: read address %0d, expected %0d", fl_addr, last_addr + 1);
          end
          reads_in_fill++;
        end
        last_addr = int'(fl_addr);
        if (off == 512) d1_data = bench_crc(blk);
        else d1_data = fdata(int'(fl_addr)) ^ ((corrupt_now && off == 7) ? 16'h0008 : 16'h0000);
        d1 = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request: returns cycles from drive to the answer
  task automatic do_req(input int addr, input int bad, input int exp_fills,
                        input bit exp_err, input string req);
    int cyc;
    int blk;
    logic [15:0] exp_data;
    blk = addr / 512;
    base_fills = fills_total;
    bad_target = bad;
    @(negedge clk);
    req_addr  = 12'(addr);
    req_valid = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_ready && cyc < 20000);
    exp_data = (bad >= 4) ? 16'h0000 : fdata(blk * 513 + addr % 512);
    chk(req_ready == 1'b1, req, "answer arrived", int'(req_ready), 1);
    chk(req_data == exp_data, req, "returned word", int'(req_data), int'(exp_data));
    chk(fills_total - base_fills == exp_fills, req, "fill attempts", fills_total - base_fills, exp_fills);
    chk(err_sticky == exp_err, req, "error flag", int'(err_sticky), int'(exp_err));
    if (exp_fills > 0)
      chk(reads_in_fill == 513, "R3", "reads in last attempt", reads_in_fill, 513);
    else
      chk(cyc == 1, "R6", "hit latency", cyc, 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R5", "answer lasts one cycle", int'(req_ready), 0);
  endtask

  // {addr[11:0], corrupted attempts[3:0], expected attempts[3:0]}
  localparam logic [19:0] VEC [8] = '{
    {12'h005, 4'd0, 4'd1},   // R1 R2 R5 first miss in block 0
    {12'h1FF, 4'd0, 4'd0},   // R6 hit, last word of block
    {12'h000, 4'd0, 4'd0},   // R6 hit, first word
    {12'h207, 4'd1, 4'd2},   // R4 one bad attempt on the corrupted word
    {12'h207, 4'd0, 4'd0},   // R6 hit after recovery
    {12'hE10, 4'd3, 4'd4},   // R4 three bad attempts, fourth passes
    {12'h005, 4'd0, 4'd1},   // R3 block 0 no longer held
    {12'h3FF, 4'd2, 4'd3}    // R4 R2 two bad attempts
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready in reset", int'(req_ready), 0);
    chk(fl_own_req == 1'b0, "R9", "own in reset", int'(fl_own_req), 0);
    chk(fl_rd == 1'b0, "R9", "read in reset", int'(fl_rd), 0);
    chk(err_sticky == 1'b0, "R9", "error in reset", int'(err_sticky), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++)
      do_req(int'(VEC[v][19:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0, "R5");

    // give-up: four bad attempts in a row
    do_req(12'h400 + 3, 4, 4, 1'b1, "R7");
    // same block again with clean reads: sticky flag stays, block reread
    do_req(12'h400 + 1, 0, 1, 1'b1, "R10");
    repeat (5) @(negedge clk);
    chk(err_sticky == 1'b1, "R7", "flag still set", int'(err_sticky), 1);

    // reset clears flag and buffer: a request to the held block reads flash
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(err_sticky == 1'b0, "R9", "flag cleared by reset", int'(err_sticky), 0);
    rst_n = 1'b1;
    do_req(12'h400 + 9, 0, 1, 1'b0, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_checks + mon_checks + 1, n_fails + mon_fails + 1);
    $finish;
  end
endmodule